// File: doc/BRIEF.md
# Receive Byte Queue with Two-Threshold RTS Control

This block buffers received UART bytes between a serial-to-parallel receiver and a host. Bytes come in through a valid/data write port. The host takes them out with a read strobe, and the dequeued byte appears on a registered data output. The queue holds 64 bytes. It reports its fill count, empty and full flags, and a sticky overrun flag.

The block also drives an active-low request-to-send pin from the fill level. One 8-bit flow-control setting carries two 4-bit fields, and each field is multiplied by four to give a byte count. When the fill level reaches the upper (halt) count, the request drops and the remote sender stops. The request returns only when the level falls back to the lower (resume) count. The sender may be halfway through one more character when the request drops, so the queue keeps enough room above the halt level to store that character. When automatic control is switched off, the pin follows a software request bit.

Top module: `rx_flow_fifo`

## Requirements
- R1: While reset is held and after it is released, fill_count is 0, empty is 1, full is 0, overrun is 0, rd_data is 0, and rts_n is 0 when auto_rts_en is 1.
- R2: Bytes leave in the order they were written. After 64 writes with no reads, full is 1 and fill_count is 64.
- R3: The halt count is flow_cfg[3:0] times 4. With auto_rts_en at 1, rts_n goes to 1 on the same clock edge on which fill_count reaches the halt count.
- R4: The resume count is flow_cfg[7:4] times 4. When the resume count is below the halt count and rts_n is 1, rts_n stays 1 while fill_count is above the resume count. It returns to 0 on the edge where fill_count falls to the resume count.
- R5: A byte written after rts_n has gone to 1 is stored, raises fill_count above the halt count, and is read back in order.
- R6: With auto_rts_en at 0, rts_n equals the inverse of sw_rts, and the fill level has no effect on it.
- R7: A write to a full queue is dropped. fill_count stays at 64, the stored bytes are unchanged, and overrun goes to 1 and stays at 1 until reset.
- R8: A read strobe on an empty queue leaves rd_data unchanged and fill_count at 0.
- R9: A write and a read in the same cycle leave fill_count unchanged when the queue is neither empty nor full. When the queue is full, the read is done and the write is dropped with overrun set (count 63). When the queue is empty, the write is stored and the read is ignored (count 1).
- R10: When the resume count is not below the halt count, rts_n is 0 exactly when fill_count is below the halt count (auto_rts_en at 1).
- R11: A read strobe on a non-empty queue puts the oldest byte on rd_data in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_valid | input | 1 | A received byte is present on wr_data |
| wr_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Host dequeues one byte |
| rd_data | output | 8 | Last dequeued byte |
| flow_cfg | input | 8 | [3:0] halt field, [7:4] resume field, each in units of 4 bytes |
| auto_rts_en | input | 1 | 1 selects level-driven RTS, 0 selects sw_rts |
| sw_rts | input | 1 | Software request, 1 means request active |
| rts_n | output | 1 | Request-to-send pin, active low |
| fill_count | output | 7 | Bytes held, 0 to 64 |
| empty | output | 1 | fill_count is 0 |
| full | output | 1 | fill_count is 64 |
| overrun | output | 1 | Sticky: a write was dropped |

## Verification
A receiver write and a host read can land in the same cycle. Three fill states change the result: empty, full, and anything in between. The bench drives both strobes together in a single cycle in each of those states. It then judges fill_count, overrun and the byte that comes out against the cases listed in R9. Halt and resume are also checked on the exact edge where fill_count reaches each count, so an off-by-one in the hysteresis compare shows up as an rts_n that changes one byte late.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Each threshold field counts groups of 2**THR_SHIFT bytes.
  localparam int THR_SHIFT = 2;
  localparam int THR_W     = 4;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     level,
  output logic [CW-1:0]     level_nxt,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_nxt, rp_q, rp_nxt;
  logic [CW-1:0]     lvl_q;
  logic [DATA_W-1:0] rd_q, rd_nxt;
  logic              ovr_q, ovr_nxt;
  logic              wr_ok, rd_ok;

  always_comb begin
    wr_ok   = wr_valid && (lvl_q != CW'(DEPTH));
    rd_ok   = rd_strobe && (lvl_q != '0);
    wp_nxt  = wr_ok ? wp_q + AW'(1) : wp_q;
    rp_nxt  = rd_ok ? rp_q + AW'(1) : rp_q;
    rd_nxt  = rd_ok ? mem[rp_q] : rd_q;
    ovr_nxt = ovr_q || (wr_valid && !wr_ok);
    case ({wr_ok, rd_ok})
      2'b10:   level_nxt = lvl_q + CW'(1);
      2'b01:   level_nxt = lvl_q - CW'(1);
      default: level_nxt = lvl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      rd_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_nxt;
      rp_q  <= rp_nxt;
      lvl_q <= level_nxt;
      rd_q  <= rd_nxt;
      ovr_q <= ovr_nxt;
    end
  end

  assign rd_data = rd_q;
  assign level   = lvl_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/rxf_rts_ctrl.sv
module rxf_rts_ctrl
  import rxf_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*THR_W-1:0] cfg,
  input  logic [CW-1:0]    level_nxt,
  output logic             rts_act
);
  logic [CW-1:0] halt_b, resume_b;
  logic          hyst_ok;
  logic          act_q, act_nxt;

  always_comb begin
    halt_b   = CW'(cfg[THR_W-1:0]) << THR_SHIFT;
    resume_b = CW'(cfg[2*THR_W-1:THR_W]) << THR_SHIFT;
    hyst_ok  = resume_b < halt_b;
    if (!hyst_ok || act_q) act_nxt = level_nxt < halt_b;
    else                   act_nxt = level_nxt <= resume_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b1;
    else        act_q <= act_nxt;
  end

  assign rts_act = act_q;
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_strobe,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [2*THR_W-1:0]         flow_cfg,
  input  logic                       auto_rts_en,
  input  logic                       sw_rts,
  output logic                       rts_n,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       empty,
  output logic                       full,
  output logic                       overrun
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] lvl_nxt;
  logic          rts_act;

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .level     (fill_count),
    .level_nxt (lvl_nxt),
    .overrun   (overrun)
  );

  rxf_rts_ctrl #(.CW(CW)) u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (flow_cfg),
    .level_nxt (lvl_nxt),
    .rts_act   (rts_act)
  );

  assign rts_n = auto_rts_en ? ~rts_act : ~sw_rts;
  assign empty = (fill_count == '0);
  assign full  = (fill_count == CW'(DEPTH));
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] rd_data,
  input logic [2*THR_W-1:0] flow_cfg,
  input logic              auto_rts_en,
  input logic              rts_n,
  input logic [CW-1:0]     fill_count,
  input logic              empty,
  input logic              full,
  input logic              overrun
);
  logic [CW-1:0] halt_b;
  assign halt_b = CW'(flow_cfg[THR_W-1:0]) << THR_SHIFT;

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && $stable(flow_cfg) && halt_b != '0 && fill_count >= halt_b) |-> rts_n);

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_strobe) |=> (fill_count == $past(fill_count)) && overrun);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_strobe && !wr_valid) |=> $stable(rd_data) && (fill_count == '0));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  p_both_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && wr_valid && rd_strobe) |=> $stable(fill_count));
endmodule

bind rx_flow_fifo rxf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .rd_strobe   (rd_strobe),
  .rd_data     (rd_data),
  .flow_cfg    (flow_cfg),
  .auto_rts_en (auto_rts_en),
  .rts_n       (rts_n),
  .fill_count  (fill_count),
  .empty       (empty),
  .full        (full),
  .overrun     (overrun)
);

// File: tb/sim_rx_flow_fifo.sv
`timescale 1ns/1ps
module sim_rx_flow_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, rd_strobe, auto_rts_en, sw_rts;
  logic [7:0] wr_data, flow_cfg, rd_data;
  logic       rts_n, empty, full, overrun;
  logic [6:0] fill_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_flow_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .flow_cfg(flow_cfg),
    .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .rts_n(rts_n),
    .fill_count(fill_count), .empty(empty), .full(full), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic [7:0] wd, input logic rs);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_strobe = rs;
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] cfg, input logic auto_en);
    @(negedge clk);
    flow_cfg = cfg; auto_rts_en = auto_en; sw_rts = 1'b0;
    wr_valid = 1'b0; rd_strobe = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(8'h24, 1'b1);
    @(negedge clk);
    chk("R1 count", fill_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rts_n", rts_n, 0);
  endtask

  task automatic t_order_full();
    do_reset(8'h00, 1'b0);
    @(negedge clk); sw_rts = 1'b1;
    for (int i = 0; i < 64; i++) step(1'b1, 8'(i * 3 + 1), 1'b0);
    chk("R2 full", full, 1);
    chk("R2 count", fill_count, 64);
    chk("R6 sw active", rts_n, 0);
    @(negedge clk); sw_rts = 1'b0; #1;
    chk("R6 sw inactive", rts_n, 1);
    step(1'b1, 8'hEE, 1'b0);
    chk("R7 count", fill_count, 64);
    chk("R7 overrun", overrun, 1);
    for (int i = 0; i < 64; i++) begin
      step(1'b0, 8'h00, 1'b1);
      chk("R11/R2 order", rd_data, (i * 3 + 1) & 8'hFF);
    end
    chk("R7 sticky", overrun, 1);
    chk("R2 empty", empty, 1);
    step(1'b0, 8'h00, 1'b1);
    chk("R8 rd_data", rd_data, (63 * 3 + 1) & 8'hFF);
    chk("R8 count", fill_count, 0);
  endtask

  task automatic t_hyst();
    do_reset(8'h24, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b1, 8'(8'h40 + i), 1'b0);
    chk("R3 below halt", rts_n, 0);
    step(1'b1, 8'h4F, 1'b0);
    chk("R3 count", fill_count, 16);
    chk("R3 halt edge", rts_n, 1);
    step(1'b1, 8'h50, 1'b0);
    chk("R5 extra stored", fill_count, 17);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1);
    chk("R4 count 9", fill_count, 9);
    chk("R4 held", rts_n, 1);
    step(1'b0, 8'h00, 1'b1);
    chk("R4 resume edge", rts_n, 0);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1);
    chk("R5 extra byte", rd_data, 8'h50);
    chk("R5 empty", fill_count, 0);
  endtask

  task automatic t_invalid();
    do_reset(8'h44, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b1, 8'(i), 1'b0);
    chk("R10 below", rts_n, 0);
    step(1'b1, 8'h0F, 1'b0);
    chk("R10 at halt", rts_n, 1);
    step(1'b0, 8'h00, 1'b1);
    chk("R10 back below", rts_n, 0);
  endtask

  task automatic t_simul();
    do_reset(8'h00, 1'b0);
    step(1'b1, 8'hAA, 1'b1);
    chk("R9 empty both count", fill_count, 1);
    chk("R9 empty both rd", rd_data, 0);
    step(1'b1, 8'hBB, 1'b0);
    step(1'b1, 8'hCC, 1'b1);
    chk("R9 mid both count", fill_count, 2);
    chk("R9 mid both rd", rd_data, 8'hAA);
    for (int i = 0; i < 62; i++) step(1'b1, 8'(i), 1'b0);
    chk("R9 full", fill_count, 64);
    step(1'b1, 8'hDD, 1'b1);
    chk("R9 full both count", fill_count, 63);
    chk("R9 full both rd", rd_data, 8'hBB);
    chk("R9 full both overrun", overrun, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rd_strobe = 1'b0; wr_data = '0;
    flow_cfg = '0; auto_rts_en = 1'b1; sw_rts = 1'b0;
    t_reset();
    t_order_full();
    t_hyst();
    t_invalid();
    t_simul();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule